// File: doc/BRIEF.md
# Randomized Fault Injection Controller

This block runs one fault-injection experiment each time it is started. It decides when a single bit of the device under test is inverted, and where. An 8-bit linear feedback shift register supplies the randomness. Each experiment takes three successive register values. The first is the injection instant. The second is the target location. The third gives the bit to invert and the target class, which is either the register file or the data memory.

During the three draw cycles the controller holds the core under test in reset, so every experiment starts from a known state. It then releases the core and counts cycles from that release. When the count has reached the drawn instant and the external sequencer reports that the injection window is open, the block raises exactly one of two enables for one clock. The two enables are one for core registers and one for data memory. Along with the enable it presents a one-hot bit mask and the target address. A done flag follows the pulse and remains set until the next start.

The core, the memory and any comparison of results are outside the block. Their fault-insertion paths consume the enables, the mask and the address.

Top module: `fault_inject_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a start, the core reset output is low (core held in reset), both injection enables are low and done is low.
- R2: The random register shifts left by one each step, taking as its new bit 0 the XOR of its bits 7, 5, 4 and 0. It is loaded with the SEED parameter on reset, and a SEED of zero is replaced by 8'h01. It steps only during the three draw cycles of an experiment, once per cycle, and the value is captured before each step.
- R3: In draw order, the first captured value is the injection instant T (0 to 255) and the second is the location. In the third value, bits [2:0] give the bit index and bit 7 selects the target: 0 raises the register enable and 1 raises the memory enable.
- R4: The mask output is one-hot, with a 1 at the position given by the bit index.
- R5: For a memory target the address output equals the location value. For a register target it equals the location's low REG_AW bits, with zeros above them.
- R6: After an accepted start, the core reset output stays low for exactly three cycles (the draw cycles), then goes high and stays high until the next accepted start.
- R7: With the window open throughout, exactly T+1 cycles with the core released pass before the injection pulse cycle.
- R8: The injection never happens while the window input is low. If the count has already reached T, the pulse appears in the cycle after the first cycle with the window high.
- R9: Each experiment produces exactly one injection pulse, one clock long, on exactly one of the two enables.
- R10: Done rises in the cycle after the pulse and stays high until a start is accepted. A start that arrives while an experiment is drawing or running is ignored: it neither restarts the core nor steps the random register.
- R11: A start given while done is high begins a new experiment. Done falls and the core goes back into reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an experiment (accepted when idle or done) |
| window_i | input | 1 | Injection allowed while high |
| core_rst_no | output | 1 | Active-low reset to the core under test |
| inj_reg_o | output | 1 | One-cycle injection enable, register file |
| inj_mem_o | output | 1 | One-cycle injection enable, data memory |
| mask_o | output | DATA_W | One-hot mask of the bit to invert |
| addr_o | output | ADDR_W | Target register index or memory address |
| done_o | output | 1 | Experiment finished, held until next start |

## Verification
The window check assumes that window_i is a synchronous level sampled on the same clock edge that moves the controller into its pulse cycle. The bench changes window_i and start_i only at falling edges, so every value is stable at the rising edge that samples it. The one-pulse and done-after-pulse properties assume that the sequencer gives no start in the pulse cycle. The bench issues starts only while an experiment is running, to exercise R10, or once done is high.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int RND_W     = 8;
  localparam int NUM_DRAWS = 3;
  localparam int DRAW_IW   = $clog2(NUM_DRAWS);

  // draw slots, in capture order
  localparam int SLOT_TIME = 0;
  localparam int SLOT_LOC  = 1;
  localparam int SLOT_SEL  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW,
    ST_RUN,
    ST_INJ,
    ST_DONE
  } fi_state_e;

  function automatic logic [RND_W-1:0] lfsr_step(input logic [RND_W-1:0] q);
    return {q[RND_W-2:0], q[7] ^ q[5] ^ q[4] ^ q[0]};
  endfunction
endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr
  import fi_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [RND_W-1:0] q_o
);
  localparam logic [RND_W-1:0] SEED_EFF = (SEED == '0) ? 8'h01 : SEED;

  logic [RND_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= SEED_EFF;
    else if (step_i) q_q <= lfsr_step(q_q);
  end

  assign q_o = q_q;

  assert_lfsr_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);

  assert_lfsr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(q_q));
endmodule

// File: rtl/fi_draw_regs.sv
module fi_draw_regs
  import fi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [DRAW_IW-1:0] idx_i,
  input  logic [RND_W-1:0]   rnd_i,
  output logic [RND_W-1:0]   slot_o [NUM_DRAWS]
);
  for (genvar g = 0; g < NUM_DRAWS; g++) begin : g_slot
    logic [RND_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     val_q <= '0;
      else if (cap_i && (idx_i == DRAW_IW'(g)))        val_q <= rnd_i;
    end
    assign slot_o[g] = val_q;
  end
endmodule

// File: rtl/fi_mask_dec.sv
module fi_mask_dec #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BIT_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign mask_o[b] = (idx_i == BIT_W'(b));
  end

  assert_mask_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask_o) == 1);
endmodule

// File: rtl/fi_seq.sv
module fi_seq
  import fi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               window_i,
  input  logic [RND_W-1:0]   inj_time_i,
  output logic               draw_o,
  output logic [DRAW_IW-1:0] draw_idx_o,
  output logic               core_rst_no,
  output logic               inj_o,
  output logic               done_o
);
  localparam logic [RND_W-1:0] CNT_MAX = '1;

  fi_state_e          state_q;
  logic [DRAW_IW-1:0] dcnt_q;
  logic [RND_W-1:0]   cnt_q;
  logic               reached;

  assign reached = (cnt_q >= inj_time_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_DRAW;
          dcnt_q  <= '0;
        end
        ST_DRAW: begin
          dcnt_q <= dcnt_q + 1'b1;
          if (dcnt_q == DRAW_IW'(NUM_DRAWS - 1)) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (reached && window_i) state_q <= ST_INJ;
          else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        ST_INJ:  state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign draw_o      = (state_q == ST_DRAW);
  assign draw_idx_o  = dcnt_q;
  assign core_rst_no = (state_q == ST_RUN) || (state_q == ST_INJ) || (state_q == ST_DONE);
  assign inj_o       = (state_q == ST_INJ);
  assign done_o      = (state_q == ST_DONE);

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |=> !inj_o);

  assert_done_after_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |=> done_o);

  assert_window_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inj_o) |-> $past(window_i));

  assert_release_after_draw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> $past(draw_o));

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_no && !done_o) |=> core_rst_no);
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
  import fi_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED   = 8'hA5,
  parameter int               DATA_W = 8,
  parameter int               ADDR_W = 8,
  parameter int               REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              window_i,
  output logic              core_rst_no,
  output logic              inj_reg_o,
  output logic              inj_mem_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic               draw;
  logic [DRAW_IW-1:0] draw_idx;
  logic [RND_W-1:0]   rnd;
  logic [RND_W-1:0]   slot [NUM_DRAWS];
  logic               inj;
  logic               to_mem;
  logic [ADDR_W-1:0]  reg_addr;

  fi_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (draw),
    .q_o    (rnd)
  );

  fi_draw_regs u_draws (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (draw),
    .idx_i  (draw_idx),
    .rnd_i  (rnd),
    .slot_o (slot)
  );

  fi_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .window_i    (window_i),
    .inj_time_i  (slot[SLOT_TIME]),
    .draw_o      (draw),
    .draw_idx_o  (draw_idx),
    .core_rst_no (core_rst_no),
    .inj_o       (inj),
    .done_o      (done_o)
  );

  fi_mask_dec #(.DATA_W(DATA_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (slot[SLOT_SEL][BIT_W-1:0]),
    .mask_o (mask_o)
  );

  assign to_mem = slot[SLOT_SEL][RND_W-1];

  always_comb begin
    reg_addr = '0;
    reg_addr[REG_AW-1:0] = slot[SLOT_LOC][REG_AW-1:0];
  end

  assign addr_o    = to_mem ? slot[SLOT_LOC][ADDR_W-1:0] : reg_addr;
  assign inj_reg_o = inj && !to_mem;
  assign inj_mem_o = inj &&  to_mem;

  assert_one_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({inj_reg_o, inj_mem_o}) <= 1);

  assert_target_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_reg_o || inj_mem_o) |-> ($stable(addr_o) && $stable(mask_o)));
endmodule

// File: tb/tb_fault_inject_ctrl.sv
module tb_fault_inject_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       window_i = 1'b1;
  logic       core_rst_no, inj_reg_o, inj_mem_o, done_o;
  logic [7:0] mask_o, addr_o;
  logic       z_core_rst_no, z_inj_reg_o, z_inj_mem_o, z_done_o;
  logic [7:0] z_mask_o, z_addr_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_state;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_inject_ctrl #(.SEED(8'hA5)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .window_i(window_i),
    .core_rst_no(core_rst_no), .inj_reg_o(inj_reg_o), .inj_mem_o(inj_mem_o),
    .mask_o(mask_o), .addr_o(addr_o), .done_o(done_o));

  fault_inject_ctrl #(.SEED(8'h00)) dut_zero (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .window_i(window_i),
    .core_rst_no(z_core_rst_no), .inj_reg_o(z_inj_reg_o), .inj_mem_o(z_inj_mem_o),
    .mask_o(z_mask_o), .addr_o(z_addr_o), .done_o(z_done_o));

  function automatic logic [7:0] nxt(input logic [7:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[0]};
  endfunction

  function automatic logic [7:0] exp_addr(input logic [7:0] loc, input logic [7:0] sel);
    return sel[7] ? loc : {4'h0, loc[3:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    m_state = 8'hA5;
    repeat (3) @(negedge clk_i);
    chk("R1 core reset low in reset", int'(core_rst_no), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 core reset low after reset", int'(core_rst_no), 0);
    chk("R1 enables low", int'({inj_reg_o, inj_mem_o}), 0);
    chk("R1 done low", int'(done_o), 0);
  endtask

  // defer: hold window low past T; poke: issue a start while running
  task automatic run_exp(input bit defer, input bit poke, input bit zchk);
    logic [7:0] t, loc, sel;
    int n, cnt, early;
    t = m_state; m_state = nxt(m_state);
    loc = m_state; m_state = nxt(m_state);
    sel = m_state; m_state = nxt(m_state);
    window_i = !defer;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R6 core held in reset after start", int'(core_rst_no), 0);
    chk("R11 done cleared by start", int'(done_o), 0);
    n = 0;
    while (!core_rst_no && n < 10) begin @(negedge clk_i); n++; end
    chk("R6 reset cycles after start", n, 3);
    if (zchk) begin
      logic [7:0] zl, zs;
      zl = nxt(8'h01); zs = nxt(zl);
      chk("R2 zero seed address", int'(z_addr_o), int'(exp_addr(zl, zs)));
      chk("R2 zero seed mask", int'(z_mask_o), int'(8'h01 << zs[2:0]));
    end
    if (!defer) begin
      cnt = 1;
      while (!(inj_reg_o || inj_mem_o) && cnt < 400) begin
        @(negedge clk_i);
        if (!(inj_reg_o || inj_mem_o)) cnt++;
      end
      chk("R7 released cycles before pulse", cnt, int'(t) + 1);
    end else begin
      early = 0;
      for (int i = 0; i < int'(t) + 3; i++) begin
        @(negedge clk_i);
        if (inj_reg_o || inj_mem_o) early++;
      end
      chk("R8 no pulse while window low", early, 0);
      if (poke) begin
        start_i = 1'b1;
        @(negedge clk_i); start_i = 1'b0;
        chk("R10 start ignored while running", int'(core_rst_no), 1);
        chk("R10 no pulse from ignored start", int'(inj_reg_o || inj_mem_o), 0);
      end
      window_i = 1'b1;
      @(negedge clk_i);
      chk("R8 pulse one cycle after window opens", int'(inj_reg_o || inj_mem_o), 1);
    end
    chk("R3 memory enable by select bit 7", int'(inj_mem_o), int'(sel[7]));
    chk("R3 register enable by select bit 7", int'(inj_reg_o), int'(!sel[7]));
    chk("R5 target address", int'(addr_o), int'(exp_addr(loc, sel)));
    chk("R4 one-hot mask", int'(mask_o), int'(8'h01 << sel[2:0]));
    @(negedge clk_i);
    chk("R9 pulse lasts one cycle", int'({inj_reg_o, inj_mem_o}), 0);
    chk("R10 done after pulse", int'(done_o), 1);
  endtask

  task automatic test_done_hold();
    int drops = 0;
    int pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (!done_o) drops++;
      if (inj_reg_o || inj_mem_o) pulses++;
    end
    chk("R10 done held until start", drops, 0);
    chk("R9 no second pulse", pulses, 0);
    chk("R6 core stays released while done", int'(core_rst_no), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    test_reset();
    run_exp(1'b0, 1'b0, 1'b1);   // R2 R3 R7 with window open
    test_done_hold();
    run_exp(1'b1, 1'b0, 1'b0);   // R8 deferred by window
    run_exp(1'b1, 1'b1, 1'b0);   // R10 start while running ignored
    for (int k = 0; k < 5; k++) run_exp(k[0], 1'b0, 1'b0);  // R11 back-to-back
    test_done_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule